// File: doc/BRIEF.md
# Flash Command Interface Controller

This block sits between a host bus and the program/erase engine of a byte-wide flash device. Each host write cycle presents a command byte and an address. The block decodes single-cycle commands and tracks the two-cycle program and block-erase sequences. It checks each finished sequence against the supply flag, the lock state and the boot-region lock. It then either hands a one-cycle start request to the engine or records an error in an 8-bit status byte.

A read cycle returns either the array byte supplied by the memory or the status byte. The choice follows the last command written. Error bits stay set until the host clears them. The engine is stopped at once by the reset/abort pin, or by the supply flag dropping while an operation is in progress. A running erase can be suspended and later resumed.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the read mode is array (`rd_data` = `array_rdata`, `rd_is_status` = 0) and the status byte is 0x80. Bit 7 = ready, bit 6 = erase suspended, bit 5 = erase error, bit 4 = program error, bit 3 = supply low, and bits 2..0 always read 0.
- R2: Writing 0xFF selects array reads and writing 0x70 selects status reads. When idle, any byte other than 0xFF, 0x70, 0x50, 0x40 or 0x20 changes nothing.
- R3: Writing 0x40 and then any byte starts a program when the checks pass. `eng_start` is high for exactly the one cycle after the second write, with `eng_op` = 0 and the address and data taken from the second write. Bit 7 reads 0 until `eng_done`.
- R4: Writing 0x20 and then 0xD0 starts an erase. `eng_op` = 1 and the address is taken from the 0xD0 cycle.
- R5: If the byte after 0x20 is anything other than 0xD0, bits 5 and 4 are both set and no start is issued.
- R6: `vpp_hi` is sampled only on the cycle that completes a sequence. If it is low then, bit 3 and the error bit of the attempted operation are set and no start is issued. A low `vpp_hi` while idle changes nothing.
- R7: While bit 3 is set, a completed program or erase sequence sets its error bit and issues no start.
- R8: A completed sequence whose address is at or above `BOOT_BASE` sets its error bit and issues no start, unless `boot_unlock` is high.
- R9: `eng_done` with `eng_fail` sets bit 4 for a program or bit 5 for an erase. Bits 5..3 stay set until 0x50 clears them.
- R10: If `vpp_hi` falls while an operation is active, `eng_abort` rises in the same cycle. The next cycle shows ready, bit 3 and the error bit of the operation.
- R11: During an active erase, 0xB0 sets bit 6, sets bit 7 and raises `eng_hold`. While suspended, 0xD0 resumes the erase and clears bit 6, bit 7 and `eng_hold`.
- R12: A low `rst_n` drives `eng_abort` high at once and discards any half-entered sequence. After release the block returns to the R1 state.
- R13: While an operation runs unsuspended, every write other than 0x70 and 0xB0 is ignored.
- R14: After any completed sequence, suspend or resume, reads return status until a read-mode command is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset and abort pin |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | 8 | Command or program data byte |
| array_rdata | input | 8 | Byte read from the array |
| rd_data | output | 8 | Read data returned to the host |
| rd_is_status | output | 1 | High when `rd_data` carries the status byte |
| vpp_hi | input | 1 | Program supply present |
| boot_unlock | input | 1 | Boot-region write enable |
| eng_start | output | 1 | One-cycle start request to the engine |
| eng_op | output | 1 | 0 = program, 1 = erase |
| eng_addr | output | ADDR_W | Target address for the engine |
| eng_data | output | 8 | Program data for the engine |
| eng_hold | output | 1 | Engine must pause (erase suspended) |
| eng_abort | output | 1 | Engine must halt now |
| eng_done | input | 1 | Engine finished the operation |
| eng_fail | input | 1 | Engine verify failed (valid with `eng_done`) |

## Verification
A wrong sequence state shows on the very next write. Either a start pulse appears or goes missing one cycle after the completing write, or the status byte shows error bits it should not. A wrong active or suspend flag shows at once in status bits 7 and 6 and in `eng_hold` and `eng_abort`, because these decode the same registers combinationally. Lost or spurious error bits stay visible at every later status read until the clear command, because they are sticky. The sweeps over every second byte after erase setup, and over every byte written while idle, expose any decode error within a single write.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_READ_STATUS = 8'h70;
  localparam logic [7:0] CMD_CLEAR       = 8'h50;
  localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND     = 8'hB0;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_PROG, SEQ_ERASE} seq_e;

  // Status byte layout: ready, suspended, erase err, program err, supply low.
  function automatic logic [7:0] pack_status(input logic ready, input logic susp,
                                             input logic erase_err, input logic prog_err,
                                             input logic vpp_low);
    return {ready, susp, erase_err, prog_err, vpp_low, 3'b000};
  endfunction

endpackage

// File: rtl/fc_decode.sv
module fc_decode
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BOOT_BASE = 'hF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              vpp_hi,
  input  logic              boot_unlock,
  input  logic              vpp_flag,
  input  logic              busy,
  input  logic              susp,
  input  logic              op_erase,
  output logic              rd_status,
  output seq_e              seq_q,
  output logic              ev_start,
  output logic              ev_start_erase,
  output logic              ev_prog_err,
  output logic              ev_erase_err,
  output logic              ev_vpp_err,
  output logic              ev_clear,
  output logic              ev_suspend,
  output logic              ev_resume
);

  localparam logic [ADDR_W-1:0] BOOT_START = ADDR_W'(BOOT_BASE);

  function automatic logic in_boot(input logic [ADDR_W-1:0] a);
    return a >= BOOT_START;
  endfunction

  seq_e seq_d;
  logic mode_d;

  // Named events: a sequence completes on this write, and its qualification.
  logic seq_complete;
  logic want_erase;
  logic supply_refused;
  logic boot_locked;

  always_comb begin
    want_erase     = (seq_q == SEQ_ERASE);
    seq_complete   = wr_en && !busy && !susp &&
                     ((seq_q == SEQ_PROG) || (want_erase && wr_data == CMD_CONFIRM));
    supply_refused = vpp_flag || !vpp_hi;
    boot_locked    = in_boot(wr_addr) && !boot_unlock;
  end

  always_comb begin
    seq_d          = seq_q;
    mode_d         = rd_status;
    ev_start       = 1'b0;
    ev_start_erase = 1'b0;
    ev_prog_err    = 1'b0;
    ev_erase_err   = 1'b0;
    ev_vpp_err     = 1'b0;
    ev_clear       = 1'b0;
    ev_suspend     = 1'b0;
    ev_resume      = 1'b0;
    if (wr_en) begin
      if (busy) begin
        if (wr_data == CMD_READ_STATUS) mode_d = 1'b1;
        else if (wr_data == CMD_SUSPEND && op_erase) begin
          ev_suspend = 1'b1;
          mode_d     = 1'b1;
        end
      end else if (susp) begin
        case (wr_data)
          CMD_READ_ARRAY:  mode_d = 1'b0;
          CMD_READ_STATUS: mode_d = 1'b1;
          CMD_CLEAR:       ev_clear = 1'b1;
          CMD_CONFIRM: begin
            ev_resume = 1'b1;
            mode_d    = 1'b1;
          end
          default: ;
        endcase
      end else begin
        case (seq_q)
          SEQ_IDLE: begin
            case (wr_data)
              CMD_READ_ARRAY:  mode_d = 1'b0;
              CMD_READ_STATUS: mode_d = 1'b1;
              CMD_CLEAR:       ev_clear = 1'b1;
              CMD_PROG_SETUP: begin
                seq_d  = SEQ_PROG;
                mode_d = 1'b1;
              end
              CMD_ERASE_SETUP: begin
                seq_d  = SEQ_ERASE;
                mode_d = 1'b1;
              end
              default: ;
            endcase
          end
          default: begin
            seq_d  = SEQ_IDLE;
            mode_d = 1'b1;
            if (seq_complete) begin
              if (supply_refused) begin
                ev_vpp_err   = 1'b1;
                ev_prog_err  = !want_erase;
                ev_erase_err = want_erase;
              end else if (boot_locked) begin
                ev_prog_err  = !want_erase;
                ev_erase_err = want_erase;
              end else begin
                ev_start       = 1'b1;
                ev_start_erase = want_erase;
              end
            end else begin
              // Wrong byte after erase setup.
              ev_prog_err  = 1'b1;
              ev_erase_err = 1'b1;
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q     <= SEQ_IDLE;
      rd_status <= 1'b0;
    end else begin
      seq_q     <= seq_d;
      rd_status <= mode_d;
    end
  end

  assert_one_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ev_start, ev_prog_err | ev_erase_err}) <= 1);

  assert_setup_leaves_status_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_q != SEQ_IDLE && wr_en) |=> (rd_status && seq_q == SEQ_IDLE));

endmodule

// File: rtl/fc_launch.sv
module fc_launch #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_start,
  input  logic              ev_start_erase,
  input  logic              ev_suspend,
  input  logic              ev_resume,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              vpp_hi,
  input  logic              eng_done,
  output logic              op_active,
  output logic              op_erase,
  output logic              susp,
  output logic              abort_hit,
  output logic              eng_start,
  output logic [ADDR_W-1:0] eng_addr,
  output logic [7:0]        eng_data
);

  assign abort_hit = op_active && !vpp_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_active <= 1'b0;
      op_erase  <= 1'b0;
      susp      <= 1'b0;
      eng_start <= 1'b0;
      eng_addr  <= '0;
      eng_data  <= '0;
    end else begin
      eng_start <= ev_start;
      if (ev_start) begin
        op_active <= 1'b1;
        op_erase  <= ev_start_erase;
        eng_addr  <= wr_addr;
        eng_data  <= wr_data;
      end else if (abort_hit || (op_active && eng_done)) begin
        op_active <= 1'b0;
        susp      <= 1'b0;
      end else if (ev_suspend) begin
        susp <= 1'b1;
      end else if (ev_resume) begin
        susp <= 1'b0;
      end
    end
  end

  assert_single_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  assert_abort_ends_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_hit |=> (!op_active && !susp));

  assert_suspend_only_erase_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(susp) |-> op_erase);

endmodule

// File: rtl/fc_status.sv
module fc_status
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_clear,
  input  logic       ev_prog_err,
  input  logic       ev_erase_err,
  input  logic       ev_vpp_err,
  input  logic       eng_done,
  input  logic       eng_fail,
  input  logic       abort_hit,
  input  logic       op_active,
  input  logic       op_erase,
  input  logic       susp,
  output logic [7:0] status_byte
);

  logic erase_err_q, prog_err_q, vpp_low_q;
  logic verify_fail;

  assign verify_fail = op_active && eng_done && eng_fail && !abort_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      erase_err_q <= 1'b0;
      prog_err_q  <= 1'b0;
      vpp_low_q   <= 1'b0;
    end else if (ev_clear) begin
      erase_err_q <= 1'b0;
      prog_err_q  <= 1'b0;
      vpp_low_q   <= 1'b0;
    end else begin
      if (ev_erase_err || ((abort_hit || verify_fail) && op_erase))  erase_err_q <= 1'b1;
      if (ev_prog_err  || ((abort_hit || verify_fail) && !op_erase)) prog_err_q  <= 1'b1;
      if (ev_vpp_err || abort_hit) vpp_low_q <= 1'b1;
    end
  end

  assign status_byte = pack_status(!op_active || susp, susp, erase_err_q, prog_err_q, vpp_low_q);

  assert_sticky_errors_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_err_q && !ev_clear) |=> prog_err_q);

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BOOT_BASE = 'hF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [7:0]        array_rdata,
  output logic [7:0]        rd_data,
  output logic              rd_is_status,
  input  logic              vpp_hi,
  input  logic              boot_unlock,
  output logic              eng_start,
  output logic              eng_op,
  output logic [ADDR_W-1:0] eng_addr,
  output logic [7:0]        eng_data,
  output logic              eng_hold,
  output logic              eng_abort,
  input  logic              eng_done,
  input  logic              eng_fail
);

  localparam logic [ADDR_W-1:0] BOOT_START = ADDR_W'(BOOT_BASE);

  seq_e seq_q;
  logic [7:0] status_byte;
  logic op_active, op_erase, susp, abort_hit;
  logic ev_start, ev_start_erase, ev_prog_err, ev_erase_err, ev_vpp_err;
  logic ev_clear, ev_suspend, ev_resume;

  fc_decode #(.ADDR_W(ADDR_W), .BOOT_BASE(BOOT_BASE)) u_decode (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .vpp_hi(vpp_hi), .boot_unlock(boot_unlock), .vpp_flag(status_byte[3]),
    .busy(op_active && !susp), .susp(susp), .op_erase(op_erase),
    .rd_status(rd_is_status), .seq_q(seq_q),
    .ev_start(ev_start), .ev_start_erase(ev_start_erase),
    .ev_prog_err(ev_prog_err), .ev_erase_err(ev_erase_err), .ev_vpp_err(ev_vpp_err),
    .ev_clear(ev_clear), .ev_suspend(ev_suspend), .ev_resume(ev_resume)
  );

  fc_launch #(.ADDR_W(ADDR_W)) u_launch (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_start_erase(ev_start_erase),
    .ev_suspend(ev_suspend), .ev_resume(ev_resume), .wr_addr(wr_addr), .wr_data(wr_data),
    .vpp_hi(vpp_hi), .eng_done(eng_done), .op_active(op_active), .op_erase(op_erase),
    .susp(susp), .abort_hit(abort_hit), .eng_start(eng_start), .eng_addr(eng_addr),
    .eng_data(eng_data)
  );

  fc_status u_status (
    .clk(clk), .rst_n(rst_n), .ev_clear(ev_clear), .ev_prog_err(ev_prog_err),
    .ev_erase_err(ev_erase_err), .ev_vpp_err(ev_vpp_err), .eng_done(eng_done),
    .eng_fail(eng_fail), .abort_hit(abort_hit), .op_active(op_active),
    .op_erase(op_erase), .susp(susp), .status_byte(status_byte)
  );

  assign eng_op    = op_erase;
  assign eng_hold  = susp;
  assign eng_abort = !rst_n || abort_hit;
  assign rd_data   = rd_is_status ? status_byte : array_rdata;

  assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !status_byte[7]);

  assert_bad_confirm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && seq_q == SEQ_ERASE && wr_data != CMD_CONFIRM) |=>
      (!eng_start && status_byte[5] && status_byte[4]));

  assert_supply_at_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> $past(vpp_hi));

  assert_locked_supply_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_byte[3] && wr_en && seq_q != SEQ_IDLE) |=> !eng_start);

  assert_boot_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start && eng_addr >= BOOT_START) |-> $past(boot_unlock));

  assert_abort_report_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_abort |=> (status_byte[7] && status_byte[3]));

endmodule

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb;

  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] array_rdata = 8'h5A;
  logic [7:0] rd_data;
  logic rd_is_status;
  logic vpp_hi = 1'b1;
  logic boot_unlock = 1'b0;
  logic eng_start, eng_op, eng_hold, eng_abort;
  logic [AW-1:0] eng_addr;
  logic [7:0] eng_data;
  logic eng_done = 1'b0;
  logic eng_fail = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(AW), .BOOT_BASE('hF00)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .array_rdata(array_rdata), .rd_data(rd_data), .rd_is_status(rd_is_status),
    .vpp_hi(vpp_hi), .boot_unlock(boot_unlock), .eng_start(eng_start), .eng_op(eng_op),
    .eng_addr(eng_addr), .eng_data(eng_data), .eng_hold(eng_hold), .eng_abort(eng_abort),
    .eng_done(eng_done), .eng_fail(eng_fail)
  );

  function automatic logic [7:0] st(input int rdy, input int sus, input int ee,
                                    input int pe, input int vl);
    return 8'(rdy * 128 + sus * 64 + ee * 32 + pe * 16 + vl * 8);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic done_pulse(input logic fail);
    @(negedge clk);
    eng_done = 1'b1; eng_fail = fail;
    @(negedge clk);
    eng_done = 1'b0; eng_fail = 1'b0;
  endtask

  task automatic read_status(input string req, input logic [7:0] exp);
    wr('0, 8'h70);
    check(req, {24'h0, rd_data}, {24'h0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=expired expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check("R12 abort during reset", {31'h0, eng_abort}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 array mode after reset", {24'h0, rd_data}, 32'h5A);
    check("R1 not status", {31'h0, rd_is_status}, 32'h0);
    read_status("R1 reset status", st(1, 0, 0, 0, 0));
    wr('0, 8'hFF);
    array_rdata = 8'hC3;
    #1 check("R2 array select", {24'h0, rd_data}, 32'hC3);

    // R2 sweep: every non-command byte while idle does nothing
    for (int v = 0; v < 256; v++) begin
      if (v == 'hFF || v == 'h70 || v == 'h50 || v == 'h40 || v == 'h20) continue;
      array_rdata = 8'(v ^ 8'h3C);
      wr(12'h010, 8'(v));
      check("R2 unknown byte ignored", {23'h0, eng_start, rd_data}, {23'h0, 1'b0, 8'(v ^ 8'h3C)});
    end
    read_status("R2 status untouched", st(1, 0, 0, 0, 0));

    // R3 program start and busy
    wr(12'h123, 8'h40);
    wr(12'h234, 8'hA7);
    check("R3 start pulse", {31'h0, eng_start}, 32'h1);
    check("R3 op program", {31'h0, eng_op}, 32'h0);
    check("R3 address from second cycle", {20'h0, eng_addr}, 32'h234);
    check("R3 data", {24'h0, eng_data}, 32'hA7);
    check("R14 status read after sequence", {24'h0, rd_data}, {24'h0, st(0, 0, 0, 0, 0)});
    @(negedge clk);
    check("R3 start one cycle", {31'h0, eng_start}, 32'h0);
    // R13 writes while busy ignored
    wr('0, 8'hFF);
    check("R13 read array ignored while busy", {31'h0, rd_is_status}, 32'h1);
    wr('0, 8'h40);
    wr('0, 8'h66);
    check("R13 no start while busy", {31'h0, eng_start}, 32'h0);
    done_pulse(1'b0);
    check("R3 ready after done", {24'h0, rd_data}, {24'h0, st(1, 0, 0, 0, 0)});
    wr('0, 8'h11);
    check("R13 no pending setup after busy", {31'h0, eng_start}, 32'h0);

    // R9 verify failure, stickiness, clear
    wr(12'h050, 8'h40);
    wr(12'h050, 8'h00);
    done_pulse(1'b1);
    check("R9 program fail bit", {24'h0, rd_data}, {24'h0, st(1, 0, 0, 1, 0)});
    wr('0, 8'hFF);
    read_status("R9 sticky program error", st(1, 0, 0, 1, 0));
    wr('0, 8'h50);
    check("R9 clear", {24'h0, rd_data}, {24'h0, st(1, 0, 0, 0, 0)});
    wr(12'h300, 8'h20);
    wr(12'h300, 8'hD0);
    done_pulse(1'b1);
    check("R9 erase fail bit", {24'h0, rd_data}, {24'h0, st(1, 0, 1, 0, 0)});
    wr('0, 8'h50);

    // R4 erase, address from confirm cycle
    wr(12'h111, 8'h20);
    wr(12'h4C0, 8'hD0);
    check("R4 erase start", {30'h0, eng_start, eng_op}, 32'h3);
    check("R4 address from confirm", {20'h0, eng_addr}, 32'h4C0);
    // R11 suspend and resume
    wr('0, 8'hB0);
    check("R11 suspended status", {24'h0, rd_data}, {24'h0, st(1, 1, 0, 0, 0)});
    check("R11 hold high", {31'h0, eng_hold}, 32'h1);
    wr('0, 8'hFF);
    check("R11 array reads while suspended", {31'h0, rd_is_status}, 32'h0);
    wr('0, 8'hD0);
    check("R11 resumed status", {24'h0, rd_data}, {24'h0, st(0, 0, 0, 0, 0)});
    check("R11 hold low", {31'h0, eng_hold}, 32'h0);
    done_pulse(1'b0);
    check("R4 erase done", {24'h0, rd_data}, {24'h0, st(1, 0, 0, 0, 0)});

    // R5 sweep over every wrong confirm byte
    for (int v = 0; v < 256; v++) begin
      if (v == 'hD0) continue;
      wr(12'h200, 8'h20);
      wr(12'h200, 8'(v));
      check("R5 wrong confirm", {23'h0, eng_start, rd_data}, {23'h0, 1'b0, st(1, 0, 1, 1, 0)});
      wr('0, 8'h50);
    end
    check("R5 cleared", {24'h0, rd_data}, {24'h0, st(1, 0, 0, 0, 0)});

    // R6 supply sampled only at completion
    vpp_hi = 1'b0;
    repeat (4) @(negedge clk);
    read_status("R6 idle low supply no effect", st(1, 0, 0, 0, 0));
    wr(12'h020, 8'h40);
    vpp_hi = 1'b1;
    wr(12'h020, 8'h99);
    check("R6 start when supply high at completion", {31'h0, eng_start}, 32'h1);
    done_pulse(1'b0);
    vpp_hi = 1'b0;
    wr(12'h020, 8'h40);
    wr(12'h020, 8'h99);
    check("R6 supply low refused", {23'h0, eng_start, rd_data}, {23'h0, 1'b0, st(1, 0, 0, 1, 1)});
    // R7 refusal while supply flag set
    vpp_hi = 1'b1;
    wr(12'h400, 8'h20);
    wr(12'h400, 8'hD0);
    check("R7 erase refused", {23'h0, eng_start, rd_data}, {23'h0, 1'b0, st(1, 0, 1, 1, 1)});
    wr('0, 8'h50);
    check("R7 clear", {24'h0, rd_data}, {24'h0, st(1, 0, 0, 0, 0)});

    // R8 boot region lock
    wr(12'hF10, 8'h40);
    wr(12'hF10, 8'h12);
    check("R8 boot program locked", {23'h0, eng_start, rd_data}, {23'h0, 1'b0, st(1, 0, 0, 1, 0)});
    wr('0, 8'h50);
    wr(12'hFFF, 8'h20);
    wr(12'hFFF, 8'hD0);
    check("R8 boot erase locked", {23'h0, eng_start, rd_data}, {23'h0, 1'b0, st(1, 0, 1, 0, 0)});
    wr('0, 8'h50);
    wr(12'hEFF, 8'h40);
    wr(12'hEFF, 8'h12);
    check("R8 below boot base allowed", {31'h0, eng_start}, 32'h1);
    done_pulse(1'b0);
    boot_unlock = 1'b1;
    wr(12'hF00, 8'h20);
    wr(12'hF00, 8'hD0);
    check("R8 unlocked boot erase", {31'h0, eng_start}, 32'h1);
    done_pulse(1'b0);
    boot_unlock = 1'b0;

    // R10 supply drop during operation
    wr(12'h070, 8'h40);
    wr(12'h070, 8'h01);
    @(negedge clk);
    vpp_hi = 1'b0;
    #1 check("R10 abort same cycle", {31'h0, eng_abort}, 32'h1);
    @(negedge clk);
    check("R10 status after abort", {24'h0, rd_data}, {24'h0, st(1, 0, 0, 1, 1)});
    check("R10 abort released", {31'h0, eng_abort}, 32'h0);
    vpp_hi = 1'b1;
    wr('0, 8'h50);

    // R12 reset mid-operation and pending setup discard
    wr(12'h080, 8'h20);
    wr(12'h080, 8'hD0);
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R12 abort on reset", {31'h0, eng_abort}, 32'h1);
    @(negedge clk);
    rst_n = 1'b1;
    array_rdata = 8'h77;
    @(negedge clk);
    check("R12 array mode after reset", {24'h0, rd_data}, 32'h77);
    wr(12'h090, 8'h40);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    wr(12'h090, 8'h12);
    check("R12 setup discarded", {23'h0, eng_start, rd_data}, {23'h0, 1'b0, 8'h77});
    read_status("R12 status after reset", st(1, 0, 0, 0, 0));

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule